// File: doc/BRIEF.md
# Prescaled Periodic Down-Counter Timer

This block is a 32-bit periodic timer reached over a narrow 16-bit register bus. An internal prescaler divides the system clock so that the main counter steps down by one once every (D+1) clocks, where D is a 32-bit divide value. When the main counter is at zero and the next step arrives, the counter reloads from a 32-bit period value and the block raises a one-clock interrupt pulse. A full cycle of the timer therefore lasts (P+1)×(D+1) clocks for period value P.

Every 32-bit quantity (live count, period, divide value) is split into a low and a high 16-bit half, and each half has its own word address. A control word holds a run/hold flag and a self-clearing reload strobe. Reads are registered and return the addressed half one clock after the address is presented.

Top module: `prescaled_down_timer`

## Requirements
- R1: After reset the live count, period and divide value read as zero, the control word reads 0x0010 (hold flag set) and `irq` is low.
- R2: Word addresses: 0 count low, 1 count high, 2 period low, 3 period high, 4 control, 6 divide low, 7 divide high. Address 5 and control bits other than bit 4 read as zero. `rd_data` shows the half selected by `addr` one clock later.
- R3: While running, the count falls by exactly one every (D+1) clocks, borrowing from the high half into the low half.
- R4: When a step arrives with the count at zero, the count takes the period value and `irq` is high for that one clock; consecutive pulses are (P+1)×(D+1) clocks apart.
- R5: While control bit 4 (hold) is 1, the count and prescaler keep their values and `irq` stays low.
- R6: Writing control with bit 5 set loads the count from the period value and the prescaler from D; bit 5 reads back as 0.
- R7: A bus write to a count half takes priority over a step in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one 16-bit word |
| addr | input | 3 | Word address for reads and writes |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data for the previous cycle's `addr` |
| irq | output | 1 | One-clock pulse on each reload from zero |

## Verification
The stepping rate is tried with a divide of zero against a count that must borrow across the 16-bit boundary, and with a divide of two against a count that stays in the low half, which separates a wrong divide ratio from a broken borrow. Pulse spacing is measured over random small period and divide pairs from a fixed seed, including the zero/zero case, so an off-by-one in either the prescaler or the zero reload shows as a wrong interval. A count write placed while stepping every clock tells write priority apart from a lost or doubled step, and a long hold window checks that nothing moves and no pulse escapes.

// File: rtl/pdt_pkg.sv
package pdt_pkg;
   localparam int unsigned ADDR_W = 3;
   localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
   localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
   localparam logic [ADDR_W-1:0] A_PRD_LO = 3'd2;
   localparam logic [ADDR_W-1:0] A_PRD_HI = 3'd3;
   localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;
   localparam logic [ADDR_W-1:0] A_DIV_LO = 3'd6;
   localparam logic [ADDR_W-1:0] A_DIV_HI = 3'd7;
   localparam int unsigned HOLD_BIT   = 4;
   localparam int unsigned RELOAD_BIT = 5;
endpackage

// File: rtl/pdt_prescaler.sv
module pdt_prescaler #(
   parameter int unsigned CNT_W  = 32,
   parameter bit          USE_DIV = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             load,
   input  logic [CNT_W-1:0] div,
   output logic             tick
);
   generate
      if (USE_DIV) begin : g_div
         logic [CNT_W-1:0] psc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               psc_q <= '0;
            end else if (load) begin
               psc_q <= div;
            end else if (run) begin
               if (psc_q == '0) psc_q <= div;
               else             psc_q <= psc_q - 1'b1;
            end
         end
         assign tick = run && !load && (psc_q == '0);
      end else begin : g_nodiv
         logic unused_div;
         assign unused_div = ^div;
         assign tick = run && !load;
      end
   endgenerate
endmodule

// File: rtl/pdt_counter.sv
module pdt_counter #(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DATA_W = 16,
   localparam int unsigned HALVES = CNT_W / DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HALVES-1:0] wr_half,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              load,
   input  logic              tick,
   input  logic [CNT_W-1:0]  prd,
   output logic [CNT_W-1:0]  cnt,
   output logic              irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         irq <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (|wr_half) begin
            for (int h = 0; h < HALVES; h++) begin
               if (wr_half[h]) cnt[h*DATA_W +: DATA_W] <= wr_data;
            end
         end else if (load) begin
            cnt <= prd;
         end else if (tick) begin
            if (cnt == '0) begin
               cnt <= prd;
               irq <= 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pdt_regs.sv
module pdt_regs #(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DATA_W = 16,
   localparam int unsigned HALVES = CNT_W / DATA_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [pdt_pkg::ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0]         wr_data,
   input  logic [CNT_W-1:0]          cnt,
   output logic [HALVES-1:0]         wr_cnt,
   output logic                      load,
   output logic                      hold,
   output logic [CNT_W-1:0]          prd,
   output logic [CNT_W-1:0]          div,
   output logic [DATA_W-1:0]         rd_data
);
   import pdt_pkg::*;

   logic wr_ctrl;
   assign wr_ctrl = wr_en && (addr == A_CTRL);
   assign load    = wr_ctrl && wr_data[RELOAD_BIT];
   assign wr_cnt  = {wr_en && (addr == A_CNT_HI), wr_en && (addr == A_CNT_LO)};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prd  <= '0;
         div  <= '0;
         hold <= 1'b1;
      end else begin
         if (wr_en && addr == A_PRD_LO) prd[DATA_W-1:0]      <= wr_data;
         if (wr_en && addr == A_PRD_HI) prd[CNT_W-1:DATA_W]  <= wr_data;
         if (wr_en && addr == A_DIV_LO) div[DATA_W-1:0]      <= wr_data;
         if (wr_en && addr == A_DIV_HI) div[CNT_W-1:DATA_W]  <= wr_data;
         if (wr_ctrl)                   hold                 <= wr_data[HOLD_BIT];
      end
   end

   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      unique case (addr)
         A_CNT_LO: rd_mux = cnt[DATA_W-1:0];
         A_CNT_HI: rd_mux = cnt[CNT_W-1:DATA_W];
         A_PRD_LO: rd_mux = prd[DATA_W-1:0];
         A_PRD_HI: rd_mux = prd[CNT_W-1:DATA_W];
         A_CTRL:   rd_mux[HOLD_BIT] = hold;
         A_DIV_LO: rd_mux = div[DATA_W-1:0];
         A_DIV_HI: rd_mux = div[CNT_W-1:DATA_W];
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= rd_mux;
   end
endmodule

// File: rtl/prescaled_down_timer.sv
module prescaled_down_timer #(
   parameter int unsigned CNT_W   = 32,
   parameter int unsigned DATA_W  = 16,
   parameter bit          USE_DIV = 1'b1,
   localparam int unsigned HALVES = CNT_W / DATA_W
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [pdt_pkg::ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0]          wr_data,
   output logic [DATA_W-1:0]          rd_data,
   output logic                       irq
);
   generate
      if (HALVES != 2 || CNT_W != HALVES * DATA_W) begin : g_bad_width
         $error("prescaled_down_timer: CNT_W must be exactly twice DATA_W");
      end
      if (DATA_W <= pdt_pkg::RELOAD_BIT) begin : g_bad_data
         $error("prescaled_down_timer: DATA_W too narrow for control bits");
      end
   endgenerate

   logic [HALVES-1:0] wr_cnt;
   logic              load;
   logic              stop_q;
   logic              tick;
   logic [CNT_W-1:0]  prd_q;
   logic [CNT_W-1:0]  div_q;
   logic [CNT_W-1:0]  cnt_q;

   pdt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .cnt(cnt_q), .wr_cnt(wr_cnt), .load(load), .hold(stop_q),
      .prd(prd_q), .div(div_q), .rd_data(rd_data)
   );

   pdt_prescaler #(.CNT_W(CNT_W), .USE_DIV(USE_DIV)) u_psc (
      .clk(clk), .rst_n(rst_n), .run(!stop_q), .load(load),
      .div(div_q), .tick(tick)
   );

   pdt_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .wr_half(wr_cnt), .wr_data(wr_data),
      .load(load), .tick(tick), .prd(prd_q), .cnt(cnt_q), .irq(irq)
   );
endmodule

// File: rtl/pdt_checker.sv
module pdt_checker #(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned DATA_W = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       wr_en,
   input logic [pdt_pkg::ADDR_W-1:0] addr,
   input logic [DATA_W-1:0]          wr_data,
   input logic                       irq,
   input logic                       stop,
   input logic                       tick,
   input logic [CNT_W-1:0]           cnt,
   input logic [CNT_W-1:0]           prd
);
   import pdt_pkg::*;

   p_dec_by_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop && !wr_en && tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

   p_idle_between_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop && !wr_en && !tick) |=> ($stable(cnt) && !irq));

   p_irq_from_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($past(cnt) == '0 && cnt == $past(prd)));

   p_hold_freezes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !wr_en) |=> ($stable(cnt) && !irq));

   p_reload_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CTRL && wr_data[RELOAD_BIT]) |=> (cnt == $past(prd) && !irq));

   p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CNT_LO) |=> (cnt[DATA_W-1:0] == $past(wr_data)));
endmodule

bind prescaled_down_timer pdt_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
   .irq(irq), .stop(stop_q), .tick(tick), .cnt(cnt_q), .prd(prd_q)
);

// File: tb/prescaled_down_timer_bench.sv
module prescaled_down_timer_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        irq;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   prescaled_down_timer u_prescaled_down_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] v);
      @(negedge clk);
      addr = a;
      @(negedge clk);
      v = rd_data;
   endtask

   task automatic set32(input logic [2:0] lo, input logic [31:0] v);
      wr(lo, v[15:0]);
      wr(lo + 3'd1, v[31:16]);
   endtask

   function automatic int unsigned expect_interval(int unsigned p, int unsigned d);
      return (p + 1) * (d + 1);
   endfunction

   function automatic logic [31:0] expect_count(logic [31:0] p, int unsigned d, int unsigned edges);
      return p - edges / (d + 1);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] v, v2;
      int unsigned seed_set;
      seed_set = $urandom(32'd20240611);

      repeat (3) @(negedge clk);
      check("R1 irq in reset", {31'b0, irq}, 32'd0);
      rst_n = 1'b1;

      // R1 reset values at every address (R2 offset 5 zero)
      for (int a = 0; a < 8; a++) begin
         rd(a[2:0], v);
         check((a == 4) ? "R1 control reset" : "R1 register reset", {16'b0, v},
               (a == 4) ? 32'h10 : 32'h0);
      end

      // R2 half addressing and readback
      set32(3'd2, 32'hA5C3_0F1E);
      set32(3'd6, 32'h0001_7E57);
      rd(3'd2, v); check("R2 period low", {16'b0, v}, 32'h0F1E);
      rd(3'd3, v); check("R2 period high", {16'b0, v}, 32'hA5C3);
      rd(3'd6, v); check("R2 divide low", {16'b0, v}, 32'h7E57);
      rd(3'd7, v); check("R2 divide high", {16'b0, v}, 32'h0001);
      wr(3'd5, 16'hFFFF);
      rd(3'd5, v); check("R2 offset 5 reads zero", {16'b0, v}, 32'h0);
      wr(3'd4, 16'hFFDF);
      rd(3'd4, v); check("R2 control unused bits", {16'b0, v}, 32'h10);

      // R5 hold: count writes stick, nothing moves
      set32(3'd0, 32'h0000_0005);
      repeat (20) @(negedge clk);
      rd(3'd0, v); check("R5 hold keeps count", {16'b0, v}, 32'h5);

      // R6 reload strobe loads count from period, bit reads zero
      wr(3'd4, 16'h0030);
      rd(3'd0, v);  rd(3'd1, v2);
      check("R6 reload from period", {v2, v}, 32'hA5C3_0F1E);
      rd(3'd4, v); check("R6 reload bit reads zero", {16'b0, v}, 32'h10);

      // R3 rate with divide 2, low half only
      set32(3'd2, 32'd1000);
      set32(3'd6, 32'd2);
      wr(3'd4, 16'h0030);
      wr(3'd4, 16'h0000);
      repeat (20) @(negedge clk);
      wr(3'd4, 16'h0010);
      rd(3'd0, v); rd(3'd1, v2);
      check("R3 rate divide 2", {v2, v}, expect_count(32'd1000, 2, 22));

      // R3 borrow across halves with divide 0
      set32(3'd2, 32'h0001_0000);
      set32(3'd6, 32'd0);
      wr(3'd4, 16'h0030);
      wr(3'd4, 16'h0000);
      repeat (5) @(negedge clk);
      wr(3'd4, 16'h0010);
      rd(3'd0, v); rd(3'd1, v2);
      check("R3 borrow across halves", {v2, v}, expect_count(32'h0001_0000, 0, 7));

      // R7 write beats a step in the same clock (divide 0 steps every clock)
      wr(3'd4, 16'h0030);
      wr(3'd4, 16'h0000);
      wr(3'd0, 16'h1234);
      wr(3'd4, 16'h0010);
      rd(3'd0, v); rd(3'd1, v2);
      check("R7 write priority", {v2, v}, 32'h0000_1232);

      // R4 pulse spacing: directed zero/zero then random pairs
      for (int it = 0; it < 10; it++) begin
         int unsigned p, d, cyc, npulse, gap_ok, width_ok;
         int unsigned t[4];
         p = (it == 0) ? 0 : $urandom_range(6, 0);
         d = (it == 0) ? 0 : ((it == 1) ? 5 : $urandom_range(5, 0));
         set32(3'd2, p);
         set32(3'd6, d);
         wr(3'd4, 16'h0030);
         wr(3'd4, 16'h0000);
         cyc = 0; npulse = 0;
         while (npulse < 4 && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (irq) begin t[npulse] = cyc; npulse++; end
         end
         wr(3'd4, 16'h0010);
         check("R4 pulses seen", npulse, 4);
         gap_ok = 1;
         for (int k = 1; k < 4; k++)
            if (t[k] - t[k-1] != expect_interval(p, d)) gap_ok = 0;
         check("R4 pulse interval", gap_ok ? expect_interval(p, d) : t[1] - t[0],
               expect_interval(p, d));
         width_ok = 1;
         if (expect_interval(p, d) > 1)
            for (int k = 1; k < 4; k++) if (t[k] == t[k-1] + 1) width_ok = 0;
         check("R4 one-clock pulse", width_ok, 1);
      end

      // R5 no pulse and no motion under hold, period 0 divide 0
      set32(3'd2, 32'd0);
      set32(3'd6, 32'd0);
      wr(3'd4, 16'h0030);
      begin
         int unsigned seen;
         seen = 0;
         rd(3'd0, v);
         repeat (30) begin @(negedge clk); if (irq) seen++; end
         rd(3'd0, v2);
         check("R5 no irq under hold", seen, 0);
         check("R5 count stable under hold", {16'b0, v2}, {16'b0, v});
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule